// File: doc/BRIEF.md
# GPIO Port with Level-Sensitive Interrupt Controller

A 32-pin general-purpose I/O port with a small interrupt controller beside it, reached through a single-cycle register interface. A window-select input chooses between two register windows. The I/O window holds the direction, data, polarity and status registers. The controller window holds a read-only pending view and a mask register. Each pin enters through a two-flop synchronizer. The synchronized value feeds both data reads and level detection.

Interrupts are level-sensitive only. A per-pin polarity bit selects whether a high or a low level counts as active. A status bit latches whenever its pin sits at the active level. Software clears status bits by writing zeros to them. Bits written as one keep their value, so writing the complement of a one-hot pattern acknowledges exactly one pin. The host sees one combined interrupt line. That line is raised whenever a pending bit is set and its mask bit is clear. All sources start out masked.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, direction is 0 (all pins inputs, `pin_oe` 0), data is 0, polarity is all ones, status is 0, mask is 0xFFFFFFFF and `host_irq` is 0.
- R2: A write to I/O offset 0x0 sets direction and a write to I/O offset 0x4 sets the data register. `pin_oe` equals direction and `pin_out` equals the data register. Both take effect on the clock edge of the write.
- R3: Reading I/O offset 0x4 returns, per bit, the data register where direction is 1 and the synchronized pin where direction is 0. A pin change is first visible in a read after the second rising edge that follows it.
- R4: I/O offset 0x8 holds polarity (1 = active high, 0 = active low). A status bit (I/O offset 0xC) sets on the third rising edge after its pin reaches the active level.
- R5: A write to status clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: If a status write clears a bit whose pin is still active, the bit stays set. Setting has priority over clearing.
- R7: Controller offset 0x0 reads back the status register. Writes to it are ignored.
- R8: Controller offset 0x8 holds the mask, where 1 blocks a pin. `host_irq` is 1 exactly when some status bit is set with its mask bit clear.
- R9: Reads of unmapped offsets return 0, and writes to them change no register. The unmapped offsets are I/O offsets other than 0x0, 0x4, 0x8 and 0xC, and controller offsets other than 0x0 and 0x8.
- R10: A set status bit stays set after its pin leaves the active level, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_win | input | 1 | Window select: 0 I/O window, 1 controller window |
| reg_addr | input | 4 | Byte offset inside the selected window |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
The bound checker checks these rules on every cycle. The mask is all ones on leaving reset. A set status bit can only fall in a cycle that follows a status write. An active synchronized level always shows up in status one edge later. The pin drive changes only after a data-register write. `host_irq` is never raised while every source is masked or while no status bit is set. The directed scenarios cover the remaining behaviour. These are the exact latency of the synchronizer and of status capture, mixed polarities on several pins, one-hot acknowledge, and the race between a clear and an active level. They also cover mask selectivity, the read-only pending view and the unmapped offsets, which can only be seen through register reads and port values.

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_win,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          host_irq
);
  localparam logic [AW-1:0] OFF_DIR  = AW'(4'h0);
  localparam logic [AW-1:0] OFF_DATA = AW'(4'h4);
  localparam logic [AW-1:0] OFF_POL  = AW'(4'h8);
  localparam logic [AW-1:0] OFF_STAT = AW'(4'hC);
  localparam logic [AW-1:0] OFF_PEND = AW'(4'h0);
  localparam logic [AW-1:0] OFF_MASK = AW'(4'h8);

  logic [N-1:0] sync1_q, sync2_q;
  logic [N-1:0] dir_q, dout_q, pol_q, stat_q, mask_q;
  logic [N-1:0] hit, stat_nx;
  logic         io_wr, ctl_wr;

  assign io_wr  = reg_we & ~reg_win;
  assign ctl_wr = reg_we &  reg_win;
  assign hit    = ~(sync2_q ^ pol_q);

  always_comb begin
    stat_nx = stat_q;
    if (io_wr && reg_addr == OFF_STAT)
      stat_nx = stat_q & reg_wdata;
    stat_nx = stat_nx | hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      pol_q   <= '1;
      stat_q  <= '0;
      mask_q  <= '1;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      stat_q  <= stat_nx;
      if (io_wr) begin
        case (reg_addr)
          OFF_DIR:  dir_q  <= reg_wdata;
          OFF_DATA: dout_q <= reg_wdata;
          OFF_POL:  pol_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (ctl_wr && reg_addr == OFF_MASK)
        mask_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_win) begin
      case (reg_addr)
        OFF_DIR:  reg_rdata = dir_q;
        OFF_DATA: reg_rdata = (dir_q & dout_q) | (~dir_q & sync2_q);
        OFF_POL:  reg_rdata = pol_q;
        OFF_STAT: reg_rdata = stat_q;
        default:  reg_rdata = '0;
      endcase
    end else begin
      case (reg_addr)
        OFF_PEND: reg_rdata = stat_q;
        OFF_MASK: reg_rdata = mask_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;
  assign host_irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_lvl_irq_chk.sv
module gpio_lvl_irq_chk #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_win,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [N-1:0]  pin_out,
  input logic          host_irq,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  hit
);
  logic stat_wr, data_wr;
  assign stat_wr = reg_we && !reg_win && reg_addr == AW'(4'hC);
  assign data_wr = reg_we && !reg_win && reg_addr == AW'(4'h4);

  // R1
  mask_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == '1));

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R4
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(hit)) == $past(hit)));

  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(pin_out));

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !host_irq);

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (|stat_q));
endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_win(reg_win), .reg_addr(reg_addr),
  .reg_we(reg_we), .pin_out(pin_out), .host_irq(host_irq),
  .stat_q(stat_q), .mask_q(mask_q), .hit(hit)
);

// File: tb/gpio_lvl_irq_test.sv
module gpio_lvl_irq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_win = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = 0;
  logic [31:0] pin_out, pin_oe;
  logic        host_irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_lvl_irq uut (
    .clk(clk), .rst_n(rst_n), .reg_win(reg_win), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .host_irq(host_irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic win, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_win = win; reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic win, logic [3:0] a, output logic [31:0] d);
    reg_win = win; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 4'h0, v); check("R1 dir", v, 32'h0);
    rd(0, 4'h8, v); check("R1 pol", v, 32'hFFFF_FFFF);
    rd(0, 4'hC, v); check("R1 status", v, 32'h0);
    rd(1, 4'h8, v); check("R1 mask", v, 32'hFFFF_FFFF);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 host_irq", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_drive_read;
    logic [31:0] v;
    wr(0, 4'h0, 32'h0000_FFFF);
    wr(0, 4'h4, 32'hA5A5_1234);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'hA5A5_1234);
    pin_in = 32'h0000_0000;
    wait_edges(3);
    @(negedge clk); pin_in = 32'hDEAD_0000;
    @(negedge clk);
    rd(0, 4'h4, v); check("R3 one edge", v, 32'h0000_1234);
    @(negedge clk);
    rd(0, 4'h4, v); check("R3 two edges", v, 32'hDEAD_1234);
    pin_in = 32'h0;
    wr(0, 4'h0, 32'h0);
    wait_edges(3);
    wr(0, 4'hC, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(0, 4'h8, 32'h0000_00F0);
    pin_in = 32'hFFFF_FF0F;
    wait_edges(3);
    wr(0, 4'hC, 32'h0);
    wait_edges(1);
    rd(0, 4'hC, v); check("R4 no match", v, 32'h0);
    pin_in = 32'hFFEF_FF2F;
    wait_edges(2);
    rd(0, 4'hC, v); check("R4 two edges", v, 32'h0);
    wait_edges(1);
    rd(0, 4'hC, v); check("R4 three edges", v, 32'h0010_0020);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    pin_in = 32'hFFFF_FF0F;
    wait_edges(4);
    rd(0, 4'hC, v); check("R10 sticky", v, 32'h0010_0020);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    wr(0, 4'hC, ~32'h0000_0020);
    rd(0, 4'hC, v); check("R5 one-hot ack", v, 32'h0010_0000);
    wr(0, 4'hC, 32'hFFFF_FFFF);
    rd(0, 4'hC, v); check("R5 ones keep", v, 32'h0010_0000);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    pin_in = 32'hFFEF_FF0F;
    wait_edges(3);
    wr(0, 4'hC, ~32'h0010_0000);
    rd(0, 4'hC, v); check("R6 set wins", v, 32'h0010_0000);
    pin_in = 32'hFFFF_FF0F;
    wait_edges(3);
    wr(0, 4'hC, ~32'h0010_0000);
    rd(0, 4'hC, v); check("R6 clear after release", v, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    pin_in = 32'hFFFF_FF2F;
    wait_edges(3);
    rd(1, 4'h0, v); check("R7 pending mirror", v, 32'h0000_0020);
    check("R8 all masked", {31'b0, host_irq}, 32'h0);
    wr(1, 4'h8, ~32'h0000_0040);
    check("R8 other pin unmasked", {31'b0, host_irq}, 32'h0);
    wr(1, 4'h8, ~32'h0000_0020);
    check("R8 unmasked raises", {31'b0, host_irq}, 32'h1);
    wr(1, 4'h0, 32'h0);
    rd(1, 4'h0, v); check("R7 pending read-only", v, 32'h0000_0020);
    pin_in = 32'hFFFF_FF0F;
    wait_edges(3);
    wr(0, 4'hC, ~32'h0000_0020);
    check("R8 ack drops irq", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(0, 4'h1, v); check("R9 io 0x1", v, 32'h0);
    rd(1, 4'h4, v); check("R9 ctl 0x4", v, 32'h0);
    rd(1, 4'hC, v); check("R9 ctl 0xC", v, 32'h0);
    wr(1, 4'h4, 32'h0000_FFFF);
    wr(1, 4'hC, 32'h0);
    rd(1, 4'h8, v); check("R9 mask untouched", v, ~32'h0000_0020);
    wr(0, 4'h2, 32'hFFFF_FFFF);
    wr(0, 4'h6, 32'h1234_5678);
    check("R9 pin_oe untouched", pin_oe, 32'h0);
    check("R9 pin_out untouched", pin_out, 32'hA5A5_1234);
    rd(0, 4'h8, v); check("R9 pol untouched", v, 32'h0000_00F0);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_edges(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_drive_read();
    t_level();
    t_sticky();
    t_ack();
    t_prio();
    t_mask();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule